// File: doc/BRIEF.md
# Round-Robin Request/Grant Bus Arbiter

This block is the central arbiter of a shared synchronous bus. It serves a small number of bus masters. Each master has a request line and a grant line of its own, and both run point to point between that master and the arbiter. At every rising clock edge the arbiter samples all requests and updates a registered grant vector. At most one bit of that vector is ever set.

A grant is a licence for a single transaction. The granted master may start only when it sees its grant set and the shared bus idle, meaning both the frame and initiator-ready lines are deasserted. The arbiter watches those two lines. When the owner starts its transaction, the arbiter withdraws that grant, which forces the master to arbitrate again for any further transaction. After a single all-clear cycle, the arbiter can hand the grant to the next requester while the previous transaction is still on the bus. The next owner is therefore already chosen when the bus goes idle.

Masters are chosen in round-robin order. Each search begins at the master that follows the one granted most recently.

Top module: `bus_grant_arbiter`

## Requirements
- R1: The cycle after reset is held, every grant is deasserted. After reset the first search begins at master 0.
- R2: No more than one grant bit is set in any cycle.
- R3: The grant never moves straight from one master to another. At least one cycle with no grant set lies between two different owners.
- R4: When no grant is set and at least one request is sampled, the next cycle grants exactly one master whose request was set.
- R5: The master picked is the first requester found when searching upward with wrap-around. The search starts one index above the most recently granted master (bit i of the request and grant vectors belongs to master i).
- R6: If the owner's request is sampled low, or no request is set at all, the next cycle shows no grant.
- R7: A transaction start is a sampled frame=1 whose previous sample had frame=0 and irdy=0. A start seen while a grant is set clears that grant in the next cycle, even when the owner keeps requesting.
- R8: A new grant may be issued while frame or irdy is asserted. A busy bus does not hold back arbitration.
- R9: A frame=1 whose previous sample had frame or irdy asserted is not a start, and it leaves the current grant in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_MASTERS | Request line of each master, bit i for master i |
| frame_i | input | 1 | Shared frame line, high = asserted |
| irdy_i | input | 1 | Shared initiator-ready line, high = asserted |
| gnt_o | output | NUM_MASTERS | Registered grant line of each master, bit i for master i |

## Verification
Two of the block's actions can land on the same clock edge: the owner's transaction start, which consumes its grant, and the owner dropping its request. The bench drives both on one edge and expects one clean clear, with the pointer still moved past that owner. A second collision is a fresh grant issued while the previous owner's frame is still asserted, which is hidden arbitration. The bench provokes it by keeping frame high across the all-clear cycle, and checks that the new grant comes without waiting for idle. A cycle-level model built from the requirements judges every cycle. That model is applied over all request patterns from every pointer position.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    BUS_BUSY = 1'b0,
    BUS_IDLE = 1'b1
  } bus_state_e;
endpackage

// File: rtl/bus_idle_tracker.sv
module bus_idle_tracker (
  input  logic clk,
  input  logic rst,
  input  logic frame_i,
  input  logic irdy_i,
  output logic start_o
);
  arb_pkg::bus_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= arb_pkg::BUS_IDLE;
    else     state_q <= (!frame_i && !irdy_i) ? arb_pkg::BUS_IDLE : arb_pkg::BUS_BUSY;
  end

  // a transaction begins when frame rises out of a sampled idle bus
  assign start_o = frame_i && (state_q == arb_pkg::BUS_IDLE);
endmodule

// File: rtl/rr_select.sv
module rr_select #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic          found_o,
  output logic [IW-1:0] winner_o
);
  localparam logic [IW:0] NW = (IW+1)'(N);

  logic [IW-1:0] cand [N];
  logic [N-1:0]  hit;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_cand
      logic [IW:0] sum;
      assign sum     = {1'b0, base_i} + (IW+1)'(k);
      assign cand[k] = (sum >= NW) ? IW'(sum - NW) : sum[IW-1:0];
      assign hit[k]  = req_i[cand[k]];
    end
  endgenerate

  always_comb begin
    found_o  = |hit;
    winner_o = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (hit[j]) winner_o = cand[j];
    end
  end
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int unsigned NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   frame_i,
  input  logic                   irdy_i,
  output logic [NUM_MASTERS-1:0] gnt_o
);
  localparam int unsigned IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NUM_MASTERS - 1);

  logic          start_seen;
  logic          found;
  logic [IW-1:0] search_base;
  logic [IW-1:0] winner;
  logic          owner_keeps;
  logic [NUM_MASTERS-1:0] win_onehot;

  bus_idle_tracker u_mon (
    .clk     (clk),
    .rst     (rst),
    .frame_i (frame_i),
    .irdy_i  (irdy_i),
    .start_o (start_seen)
  );

  rr_select #(.N(NUM_MASTERS), .IW(IW)) u_sel (
    .req_i    (req_i),
    .base_i   (search_base),
    .found_o  (found),
    .winner_o (winner)
  );

  assign owner_keeps = (|(gnt_o & req_i)) && !start_seen;
  assign win_onehot  = {{(NUM_MASTERS-1){1'b0}}, 1'b1} << winner;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      search_base <= '0;
    end else if (gnt_o != '0) begin
      if (!owner_keeps) gnt_o <= '0;
    end else if (found) begin
      gnt_o       <= win_onehot;
      search_base <= (winner == LAST) ? '0 : winner + 1'b1;
    end
  end
endmodule

// File: rtl/bus_grant_arbiter_chk.sv
module bus_grant_arbiter_chk #(
  parameter int unsigned NUM_MASTERS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_MASTERS-1:0] req_i,
  input logic                   frame_i,
  input logic                   irdy_i,
  input logic [NUM_MASTERS-1:0] gnt_o
);
  logic was_idle;
  always_ff @(posedge clk) begin
    if (rst) was_idle <= 1'b1;
    else     was_idle <= !frame_i && !irdy_i;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> gnt_o == '0); // R1
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_o)); // R2
  AST_GAP_BETWEEN_OWNERS: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && $past(gnt_o) != '0) |-> gnt_o == $past(gnt_o)); // R3
  AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o & $past(req_i)) != '0); // R4
  AST_OWNER_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && (gnt_o & req_i) == '0) |=> gnt_o == '0); // R6
  AST_START_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && frame_i && was_idle) |=> gnt_o == '0); // R7
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && (gnt_o & req_i) != '0 && !was_idle) |=> gnt_o == $past(gnt_o)); // R9
endmodule

bind bus_grant_arbiter bus_grant_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .frame_i(frame_i), .irdy_i(irdy_i), .gnt_o(gnt_o)
);

// File: tb/bus_grant_arbiter_test.sv
module bus_grant_arbiter_test;
  localparam int N = 4;
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic frame = 1'b0, irdy = 1'b0;
  logic [N-1:0] gnt;

  int n_run = 0, n_fail = 0;
  logic [N-1:0] m_g = '0;
  int m_ptr = 0;
  bit m_idle = 1'b1;

  bus_grant_arbiter #(.NUM_MASTERS(N)) uut (
    .clk(clk), .rst(rst), .req_i(req), .frame_i(frame), .irdy_i(irdy), .gnt_o(gnt)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag);
    n_run++;
    if (gnt !== m_g) begin
      n_fail++;
      $display("FAIL %s gnt=%b expected=%b", tag, gnt, m_g);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input logic [N-1:0] r, input bit f, input bit i);
    bit start = f && m_idle;
    if (m_g != '0) begin
      if ((r & m_g) == '0 || start) m_g = '0;
    end else if (r != '0) begin
      for (int k = 0; k < N; k++) begin
        int idx = (m_ptr + k) % N;
        if (r[idx]) begin
          m_g = '0; m_g[idx] = 1'b1; m_ptr = (idx + 1) % N;
          break;
        end
      end
    end
    m_idle = !f && !i;
  endtask

  task automatic cyc(input logic [N-1:0] r, input bit f, input bit i, input string tag);
    @(negedge clk);
    req = r; frame = f; irdy = i;
    @(posedge clk);
    model(r, f, i);
    #1;
    check(tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R1 reset");
    cyc(4'b1111, 0, 0, "R1 first search from 0");
    cyc(4'b0000, 0, 0, "R6 clear");

    // sweep every request pattern from every pointer position
    for (int p = 0; p < N; p++) begin
      for (int pat = 1; pat < 16; pat++) begin
        logic [N-1:0] one = '0;
        one[(p + N - 1) % N] = 1'b1;
        cyc(one, 0, 0, "R4 seed");
        cyc('0, 0, 0, "R6 seed clear");
        cyc(4'(pat), 0, 0, "R5 rr pick");
        cyc(4'(pat), 0, 0, "R3 grant held");
        cyc('0, 0, 0, "R6 no request");
      end
    end

    // hidden arbitration: master 1 and 2 request
    cyc(4'b0110, 0, 0, "R5 grant");
    cyc(4'b0110, 1, 0, "R7 start consumes grant");
    cyc(4'b0110, 1, 0, "R8 grant while frame busy");
    cyc(4'b0110, 0, 1, "R9 held while busy");
    cyc(4'b0110, 1, 1, "R9 frame without idle");
    cyc(4'b0110, 0, 0, "R9 still held");
    cyc(4'b0100, 1, 0, "R7 start with request kept");
    cyc(4'b0100, 1, 1, "R8 regrant busy");
    // start and request drop on the same edge
    cyc(4'b0000, 0, 0, "R6 drop");
    cyc(4'b1000, 0, 0, "R5 grant 3");
    cyc(4'b0000, 1, 0, "R7 start plus drop");
    cyc(4'b1001, 1, 0, "R5 wrap to 0");
    cyc(4'b1001, 1, 1, "R2 single owner");
    cyc(4'b1000, 0, 0, "R6 owner drop");
    cyc(4'b1000, 0, 0, "R3 gap then 3");

    // reset in the middle of an ownership
    @(negedge clk); rst = 1'b1; req = 4'b0010;
    @(posedge clk); m_g = '0; m_ptr = 0; m_idle = 1'b1;
    #1 check("R1 reset mid-grant");
    @(negedge clk); rst = 1'b0; req = 4'b1111;
    @(posedge clk); model(4'b1111, 0, 0);
    #1 check("R1 pointer cleared");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule